// File: doc/BRIEF.md
# Daisy-Chain Sensor Packet Relay

This block is one node in a chain of sensor boards. The node nearest the controller is downstream, and each node further from it is upstream of the one before. A one-cycle sync pulse from downstream starts a frame. The node first passes the pulse on to its upstream neighbour. It then sends its own sensor packets on two byte lanes. After that it forwards the packets that arrive from upstream, each on the lane index it came in on. Every packet is three bytes: a header byte, the high sample byte, then the low sample byte. A relayed header is raised by 0x04 at each hop, so the controller can tell which board a packet came from.

Each receive lane has a 256-entry circular byte ring. After the ring, a byte-wise aligner hunts for a header, collects the two bytes after it, and offers the complete packet to the transmit side. If a packet is cut short, the aligner drops it after a wait timeout or on a receive-error input. It then returns to header hunting, so the stream recovers without a node reset. Each lane's transmitter offers one byte at a time and moves on only when the downstream ready signal is high. The two lanes run independently, so both transmit outputs can be busy in the same cycle.

Top module: `chain_relay`

## Requirements
- R1: A rising edge on `sync_in` makes `sync_up` high for exactly the following cycle. No byte of that frame's local packets is offered while `sync_up` is high. After reset, `sync_up` and both `tx_valid` bits are 0.
- R2: No relayed byte is offered on either lane until both lanes have finished their local packets for the current frame. Before the first sync after reset, nothing is relayed.
- R3: Each packet is three bytes in this order: header, sample bits 15:8, sample bits 7:0. A local header is 0x90 plus the sensor's position within its lane (0 to 3).
- R4: Sensors 0 to 3 go out on lane 0 and sensors 4 to 7 go out on lane 1. Within a lane they go in increasing sensor order. Samples and mask are captured at the sync edge.
- R5: A sensor whose bit in `active_mask` (bit i for sensor i) is 0 sends no packet. The two lanes may therefore carry different packet counts.
- R6: A relayed packet leaves on the lane it arrived on. Its header is increased by 0x04 (modulo 256) and its two data bytes are unchanged.
- R7: Each receive lane stores up to 256 bytes in its ring, besides the packet held by its aligner. A byte that arrives while the ring is full is dropped.
- R8: Only a byte in 0x90 to 0x9F starts a packet. Any other byte seen while hunting is discarded.
- R9: If a started packet receives no further byte for `WAIT_CYCLES` cycles, it is dropped and the aligner hunts again.
- R10: A pulse on `rx_err` for a lane drops that lane's partial packet and sends the aligner back to hunting. A complete packet already held is kept.
- R11: A transmit byte is consumed only when `tx_valid` and `tx_ready` are both 1. While `tx_ready` is 0, `tx_valid` and `tx_data` hold their values.
- R12: When both lanes are relaying and both hold a complete packet, the two transmitters are busy in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Frame sync from the downstream node |
| sync_up | output | 1 | One-cycle sync pulse to the upstream node |
| samples | input | 8x16 | Local sensor samples, index i is sensor i |
| active_mask | input | 8 | Bit i enables sensor i |
| rx_data | input | 2x8 | Received byte per lane |
| rx_valid | input | 2 | Received byte strobe per lane |
| rx_err | input | 2 | Receive error (parity, overrun, framing) per lane |
| tx_data | output | 2x8 | Transmit byte per lane |
| tx_valid | output | 2 | Transmit byte offered per lane |
| tx_ready | input | 2 | Downstream ready per lane |

## Verification
The hold-while-stalled property assumes that a sync pulse does not arrive while a byte is waiting for `tx_ready`. A new frame abandons the byte in flight, so the property excludes the sync cycle, and the stimulus sends each sync only after both lanes have drained. The aligner properties assume that `rx_err` refers to bytes that have already reached the ring. The bench therefore raises errors only several cycles after the last byte of a partial packet, and it keeps received bytes back-to-back within a packet except where a timeout is intended.

// File: rtl/chain_relay_pkg.sv
package chain_relay_pkg;
    localparam int LANES         = 2;
    localparam int SENS_PER_LANE = 4;
    localparam int NUM_SENSORS   = LANES * SENS_PER_LANE;
    localparam int SAMPLE_W      = 16;
    localparam logic [7:0] HDR_BASE = 8'h90;
    localparam logic [7:0] HOP_STEP = 8'h04;

    typedef struct packed {
        logic [7:0] hdr;
        logic [7:0] hi;
        logic [7:0] lo;
    } pkt_t;

    typedef enum logic [1:0] {RX_HUNT, RX_GET1, RX_GET2, RX_HOLD} rx_state_e;
    typedef enum logic [1:0] {TX_IDLE, TX_LOCAL, TX_RELAY} tx_phase_e;

    function automatic logic is_header(input logic [7:0] b);
        return b[7:4] == HDR_BASE[7:4];
    endfunction
endpackage

// File: rtl/relay_rx_lane.sv
module relay_rx_lane
    import chain_relay_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int WAIT_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_err,
    output logic       pkt_valid,
    output pkt_t       pkt,
    input  logic       pkt_take
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int TW    = $clog2(WAIT_CYCLES + 1);
    localparam logic [ADDR_W:0] FULL_CNT = (ADDR_W + 1)'(DEPTH);
    localparam logic [TW-1:0]   WAIT_END = TW'(WAIT_CYCLES - 1);

    logic [7:0]        ring [DEPTH];
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;
    logic [ADDR_W:0]   count;
    logic [TW-1:0]     idle_cnt;
    rx_state_e         state;
    logic              wr_en, pop, full, empty;
    logic [7:0]        rd_byte;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign wr_en   = in_valid && !full;
    assign pop     = (state != RX_HOLD) && !empty && !in_err;
    assign rd_byte = ring[rd_ptr];
    assign pkt_valid = (state == RX_HOLD);

    always_ff @(posedge clk) begin
        if (wr_en) ring[wr_ptr] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (pop)   rd_ptr <= rd_ptr + 1'b1;
            unique case ({wr_en, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_HUNT;
            idle_cnt <= '0;
            pkt      <= '0;
        end else if (in_err && state != RX_HOLD) begin
            state    <= RX_HUNT;
            idle_cnt <= '0;
        end else begin
            unique case (state)
                RX_HUNT: begin
                    idle_cnt <= '0;
                    if (pop && is_header(rd_byte)) begin
                        pkt.hdr <= rd_byte;
                        state   <= RX_GET1;
                    end
                end
                RX_GET1, RX_GET2: begin
                    if (pop) begin
                        idle_cnt <= '0;
                        if (state == RX_GET1) begin
                            pkt.hi <= rd_byte;
                            state  <= RX_GET2;
                        end else begin
                            pkt.lo <= rd_byte;
                            state  <= RX_HOLD;
                        end
                    end else if (idle_cnt == WAIT_END) begin
                        idle_cnt <= '0;
                        state    <= RX_HUNT;
                    end else begin
                        idle_cnt <= idle_cnt + 1'b1;
                    end
                end
                RX_HOLD: if (pkt_take) state <= RX_HUNT;
                default: state <= RX_HUNT;
            endcase
        end
    end

    // R7: occupancy never passes the ring size
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        full && in_valid && !pop |=> full);
    // R8: a non-header byte taken while hunting leaves the aligner hunting
    p_hunt_discard_r8: assert property (@(posedge clk) disable iff (rst)
        state == RX_HUNT && pop && !is_header(rd_byte) |=> state == RX_HUNT);
    // R10: an error on a partial packet sends the aligner back to hunting
    p_err_flush_r10: assert property (@(posedge clk) disable iff (rst)
        in_err && (state == RX_GET1 || state == RX_GET2) |=> state == RX_HUNT);
    // R3: a held packet always starts with a header byte
    p_held_header_r3: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> is_header(pkt.hdr));
endmodule

// File: rtl/relay_tx_lane.sv
module relay_tx_lane
    import chain_relay_pkg::*;
(
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    frame_start,
    input  logic [SENS_PER_LANE-1:0]                mask,
    input  logic [SENS_PER_LANE-1:0][SAMPLE_W-1:0]  samples,
    input  logic                                    relay_go,
    output logic                                    local_done,
    input  logic                                    relay_valid,
    input  pkt_t                                    relay_pkt,
    output logic                                    relay_take,
    output logic [7:0]                              tx_data,
    output logic                                    tx_valid,
    input  logic                                    tx_ready
);
    localparam int SW = $clog2(SENS_PER_LANE + 1);
    localparam int IW = $clog2(SENS_PER_LANE);
    localparam logic [SW-1:0] S_END = SW'(SENS_PER_LANE);

    tx_phase_e     phase;
    logic [SW-1:0] sidx;
    logic [IW-1:0] sel;
    logic          busy;
    logic [1:0]    bidx;
    pkt_t          cur;

    assign sel        = sidx[IW-1:0];
    assign tx_valid   = busy;
    assign local_done = (phase == TX_LOCAL && sidx == S_END && !busy) || phase == TX_RELAY;
    assign relay_take = (phase == TX_RELAY) && !busy && relay_valid && !frame_start;

    always_comb begin
        unique case (bidx)
            2'd0:    tx_data = cur.hdr;
            2'd1:    tx_data = cur.hi;
            default: tx_data = cur.lo;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= TX_IDLE;
            sidx  <= '0;
            busy  <= 1'b0;
            bidx  <= '0;
            cur   <= '0;
        end else if (frame_start) begin
            phase <= TX_LOCAL;
            sidx  <= '0;
            busy  <= 1'b0;
            bidx  <= '0;
        end else if (busy) begin
            if (tx_ready) begin
                if (bidx == 2'd2) begin
                    busy <= 1'b0;
                    bidx <= '0;
                end else begin
                    bidx <= bidx + 1'b1;
                end
            end
        end else begin
            unique case (phase)
                TX_LOCAL: begin
                    if (sidx != S_END) begin
                        if (mask[sel]) begin
                            cur.hdr <= HDR_BASE + 8'(sidx);
                            cur.hi  <= samples[sel][15:8];
                            cur.lo  <= samples[sel][7:0];
                            busy    <= 1'b1;
                        end
                        sidx <= sidx + 1'b1;
                    end else if (relay_go) begin
                        phase <= TX_RELAY;
                    end
                end
                TX_RELAY: begin
                    if (relay_valid) begin
                        cur.hdr <= relay_pkt.hdr + HOP_STEP;
                        cur.hi  <= relay_pkt.hi;
                        cur.lo  <= relay_pkt.lo;
                        busy    <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R1: the local phase only begins right after a sync pulse
    p_sync_first_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == TX_LOCAL) |-> $past(frame_start));
    // R11: an offered byte is held until accepted
    p_hold_stall_r11: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready && !frame_start |=> tx_valid && $stable(tx_data));
    // R3: a local header names a sensor within this lane
    p_local_hdr_r3: assert property (@(posedge clk) disable iff (rst)
        tx_valid && phase == TX_LOCAL && bidx == 2'd0 |-> (tx_data - HDR_BASE) < 8'(SENS_PER_LANE));
endmodule

// File: rtl/chain_relay.sv
module chain_relay
    import chain_relay_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int WAIT_CYCLES = 16
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  sync_in,
    output logic                                  sync_up,
    input  logic [NUM_SENSORS-1:0][SAMPLE_W-1:0]  samples,
    input  logic [NUM_SENSORS-1:0]                active_mask,
    input  logic [LANES-1:0][7:0]                 rx_data,
    input  logic [LANES-1:0]                      rx_valid,
    input  logic [LANES-1:0]                      rx_err,
    output logic [LANES-1:0][7:0]                 tx_data,
    output logic [LANES-1:0]                      tx_valid,
    input  logic [LANES-1:0]                      tx_ready
);
    logic                                 sync_d;
    logic [NUM_SENSORS-1:0][SAMPLE_W-1:0] snap_samples;
    logic [NUM_SENSORS-1:0]               snap_mask;
    logic [LANES-1:0]                     local_done, relay_valid, relay_take;
    pkt_t                                 relay_pkt [LANES];
    logic                                 relay_go, sync_edge;

    assign sync_edge = sync_in && !sync_d;
    assign relay_go  = &local_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_d       <= 1'b0;
            sync_up      <= 1'b0;
            snap_samples <= '0;
            snap_mask    <= '0;
        end else begin
            sync_d  <= sync_in;
            sync_up <= sync_edge;
            if (sync_edge) begin
                snap_samples <= samples;
                snap_mask    <= active_mask;
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        relay_rx_lane #(.ADDR_W(ADDR_W), .WAIT_CYCLES(WAIT_CYCLES)) i_rx (
            .clk       (clk),
            .rst       (rst),
            .in_data   (rx_data[l]),
            .in_valid  (rx_valid[l]),
            .in_err    (rx_err[l]),
            .pkt_valid (relay_valid[l]),
            .pkt       (relay_pkt[l]),
            .pkt_take  (relay_take[l])
        );
        relay_tx_lane i_tx (
            .clk         (clk),
            .rst         (rst),
            .frame_start (sync_up),
            .mask        (snap_mask[l*SENS_PER_LANE +: SENS_PER_LANE]),
            .samples     (snap_samples[l*SENS_PER_LANE +: SENS_PER_LANE]),
            .relay_go    (relay_go),
            .local_done  (local_done[l]),
            .relay_valid (relay_valid[l]),
            .relay_pkt   (relay_pkt[l]),
            .relay_take  (relay_take[l]),
            .tx_data     (tx_data[l]),
            .tx_valid    (tx_valid[l]),
            .tx_ready    (tx_ready[l])
        );
    end

    // R2: a relayed packet is only taken once every lane's local packets are out
    p_relay_after_local_r2: assert property (@(posedge clk) disable iff (rst)
        (|relay_take) |-> relay_go);
    // R12: packets taken on both lanes together keep both transmitters busy
    p_parallel_r12: assert property (@(posedge clk) disable iff (rst)
        (&relay_take) && !sync_up |=> (&tx_valid));
    // R1: the upstream sync is a single-cycle pulse
    p_sync_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        sync_up |=> !sync_up);
endmodule

// File: tb/test_chain_relay.sv
`timescale 1ns/1ps
module test_chain_relay;
    import chain_relay_pkg::*;

    logic                                 clk = 1'b0;
    logic                                 rst = 1'b1;
    logic                                 sync_in = 1'b0;
    logic                                 sync_up;
    logic [NUM_SENSORS-1:0][SAMPLE_W-1:0] samples = '0;
    logic [NUM_SENSORS-1:0]               active_mask = '0;
    logic [LANES-1:0][7:0]                rx_data = '0;
    logic [LANES-1:0]                     rx_valid = '0;
    logic [LANES-1:0]                     rx_err = '0;
    logic [LANES-1:0][7:0]                tx_data;
    logic [LANES-1:0]                     tx_valid;
    logic [LANES-1:0]                     tx_ready = '1;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int stall_bad = 0;
    bit both_busy = 0;
    bit bp_mode = 0;
    bit finished = 0;

    logic [7:0] got0[$], got1[$];
    int         st0[$], st1[$];
    logic [7:0] e0[$], e1[$];

    chain_relay #(.ADDR_W(8), .WAIT_CYCLES(16)) i_chain_relay (
        .clk(clk), .rst(rst), .sync_in(sync_in), .sync_up(sync_up),
        .samples(samples), .active_mask(active_mask),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_err(rx_err),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    logic [LANES-1:0]      prev_stall = '0;
    logic [LANES-1:0][7:0] prev_data;
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            for (int l = 0; l < LANES; l++) begin
                if (prev_stall[l] && (!tx_valid[l] || tx_data[l] != prev_data[l])) stall_bad++;
                prev_stall[l] = tx_valid[l] && !tx_ready[l];
                prev_data[l]  = tx_data[l];
            end
            if (tx_valid[0] && tx_ready[0]) begin got0.push_back(tx_data[0]); st0.push_back(cyc); end
            if (tx_valid[1] && tx_ready[1]) begin got1.push_back(tx_data[1]); st1.push_back(cyc); end
            if (&tx_valid) both_busy = 1;
        end
    end

    always @(negedge clk) begin
        if (bp_mode) tx_ready[0] <= ~tx_ready[0];
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmp_lane(input int lane, input string tag);
        int bad = -1;
        logic [7:0] g[$];
        logic [7:0] x[$];
        g = (lane == 0) ? got0 : got1;
        x = (lane == 0) ? e0 : e1;
        if (g.size() == x.size())
            for (int i = 0; i < g.size(); i++) if (bad < 0 && g[i] != x[i]) bad = i;
        checks++;
        if (g.size() != x.size()) begin
            errors++;
            $display("FAIL %s lane%0d byte count actual=%0d expected=%0d", tag, lane, g.size(), x.size());
        end else if (bad >= 0) begin
            errors++;
            $display("FAIL %s lane%0d byte %0d actual=%02h expected=%02h", tag, lane, bad, g[bad], x[bad]);
        end
    endtask

    task automatic add_pkt(input int lane, input logic [7:0] h, input logic [7:0] a, input logic [7:0] b);
        if (lane == 0) begin e0.push_back(h); e0.push_back(a); e0.push_back(b); end
        else begin e1.push_back(h); e1.push_back(a); e1.push_back(b); end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rx_valid = '0; rx_err = '0; sync_in = 1'b0; tx_ready = '1; bp_mode = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        got0.delete(); got1.delete(); st0.delete(); st1.delete();
        e0.delete(); e1.delete(); both_busy = 0; stall_bad = 0; prev_stall = '0;
    endtask

    task automatic pulse_sync(output logic s1, output logic v1, output logic s2);
        @(negedge clk); sync_in = 1'b1;
        @(negedge clk); sync_in = 1'b0;
        #1; s1 = sync_up; v1 = |tx_valid;
        @(negedge clk); #1; s2 = sync_up;
    endtask

    task automatic send(input logic [7:0] q0[$], input logic [7:0] q1[$]);
        while (q0.size() > 0 || q1.size() > 0) begin
            @(negedge clk);
            rx_valid = '0;
            if (q0.size() > 0) begin rx_data[0] = q0.pop_front(); rx_valid[0] = 1'b1; end
            if (q1.size() > 0) begin rx_data[1] = q1.pop_front(); rx_valid[1] = 1'b1; end
        end
        @(negedge clk);
        rx_valid = '0;
    endtask

    task automatic relay_on();
        logic a, b, c;
        active_mask = '0;
        pulse_sync(a, b, c);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check(sync_up == 1'b0, "R1 reset sync_up", int'(sync_up), 0);
        check(tx_valid == '0, "R1 reset tx_valid", int'(tx_valid), 0);
    endtask

    task automatic t_local_all();
        logic s1, v1, s2;
        do_reset();
        for (int i = 0; i < NUM_SENSORS; i++) samples[i] = 16'hA050 + 16'(i * 16'h0123);
        active_mask = 8'hFF;
        pulse_sync(s1, v1, s2);
        check(s1 == 1'b1, "R1 sync_up after edge", int'(s1), 1);
        check(v1 == 1'b0, "R1 no byte during sync_up", int'(v1), 0);
        check(s2 == 1'b0, "R1 sync_up single cycle", int'(s2), 0);
        samples = '0;
        repeat (40) @(negedge clk);
        for (int i = 0; i < NUM_SENSORS; i++) begin
            logic [15:0] v = 16'hA050 + 16'(i * 16'h0123);
            add_pkt(i / 4, 8'h90 + 8'(i % 4), v[15:8], v[7:0]);
        end
        cmp_lane(0, "R3 R4 local lane order");
        cmp_lane(1, "R4 local lane split");
    endtask

    task automatic t_mask();
        logic s1, v1, s2;
        do_reset();
        for (int i = 0; i < NUM_SENSORS; i++) samples[i] = 16'(16'h1100 * (i + 1) + i);
        active_mask = 8'b1010_0101;
        pulse_sync(s1, v1, s2);
        repeat (30) @(negedge clk);
        add_pkt(0, 8'h90, samples[0][15:8], samples[0][7:0]);
        add_pkt(0, 8'h92, samples[2][15:8], samples[2][7:0]);
        add_pkt(1, 8'h91, samples[5][15:8], samples[5][7:0]);
        add_pkt(1, 8'h93, samples[7][15:8], samples[7][7:0]);
        cmp_lane(0, "R5 masked lane0");
        cmp_lane(1, "R5 masked lane1");
    endtask

    task automatic t_relay_order();
        logic s1, v1, s2;
        logic [7:0] q0[$], q1[$];
        do_reset();
        q0 = '{8'h90, 8'h01, 8'h02, 8'h93, 8'h03, 8'h04};
        q1 = '{8'h9C, 8'h05, 8'h06, 8'h91, 8'h07, 8'h08};
        send(q0, q1);
        repeat (5) @(negedge clk);
        check(got0.size() + got1.size() == 0, "R2 no relay before first sync", got0.size() + got1.size(), 0);
        for (int i = 0; i < NUM_SENSORS; i++) samples[i] = 16'h3300 + 16'(i);
        active_mask = 8'h0F;
        pulse_sync(s1, v1, s2);
        repeat (40) @(negedge clk);
        for (int i = 0; i < 4; i++) add_pkt(0, 8'h90 + 8'(i), 8'h33, 8'(i));
        add_pkt(0, 8'h94, 8'h01, 8'h02);
        add_pkt(0, 8'h97, 8'h03, 8'h04);
        add_pkt(1, 8'hA0, 8'h05, 8'h06);
        add_pkt(1, 8'h95, 8'h07, 8'h08);
        cmp_lane(0, "R2 R6 lane0 local then relay");
        cmp_lane(1, "R6 lane1 relay");
        if (st0.size() >= 12 && st1.size() > 0)
            check(st1[0] > st0[11], "R2 lane1 relay after lane0 local", st1[0], st0[11] + 1);
        else
            check(1'b0, "R2 timestamps present", st1.size(), 1);
    endtask

    task automatic t_parallel();
        logic [7:0] q0[$], q1[$];
        do_reset();
        relay_on();
        for (int k = 0; k < 3; k++) begin
            q0.push_back(8'h90 + 8'(k)); q0.push_back(8'(k)); q0.push_back(8'h40);
            q1.push_back(8'h98 + 8'(k)); q1.push_back(8'(k + 8)); q1.push_back(8'h41);
            add_pkt(0, 8'h94 + 8'(k), 8'(k), 8'h40);
            add_pkt(1, 8'h9C + 8'(k), 8'(k + 8), 8'h41);
        end
        send(q0, q1);
        repeat (30) @(negedge clk);
        check(both_busy, "R12 both lanes busy together", int'(both_busy), 1);
        cmp_lane(0, "R12 lane0 data");
        cmp_lane(1, "R12 lane1 data");
    endtask

    task automatic t_hunt();
        logic [7:0] q0[$], q1[$];
        do_reset();
        relay_on();
        q0 = '{8'h12, 8'h34, 8'hA0, 8'h91, 8'hAA, 8'hBB};
        send(q0, q1);
        repeat (20) @(negedge clk);
        add_pkt(0, 8'h95, 8'hAA, 8'hBB);
        cmp_lane(0, "R8 non-header bytes discarded");
    endtask

    task automatic t_timeout();
        logic [7:0] q0[$], q1[$];
        do_reset();
        relay_on();
        q1 = '{8'h92, 8'h11};
        send(q0, q1);
        repeat (40) @(negedge clk);
        q1 = '{8'h93, 8'h22, 8'h33};
        send(q0, q1);
        repeat (20) @(negedge clk);
        add_pkt(1, 8'h97, 8'h22, 8'h33);
        cmp_lane(1, "R9 stale partial dropped");
    endtask

    task automatic t_err();
        logic [7:0] q0[$], q1[$];
        do_reset();
        relay_on();
        q0 = '{8'h94, 8'h55};
        send(q0, q1);
        repeat (3) @(negedge clk);
        rx_err[0] = 1'b1;
        @(negedge clk);
        rx_err[0] = 1'b0;
        q0 = '{8'h95, 8'h66, 8'h77};
        send(q0, q1);
        repeat (20) @(negedge clk);
        add_pkt(0, 8'h99, 8'h66, 8'h77);
        cmp_lane(0, "R10 error flushes partial");
    endtask

    task automatic t_backpressure();
        logic [7:0] q0[$], q1[$];
        do_reset();
        relay_on();
        bp_mode = 1;
        for (int k = 0; k < 4; k++) begin
            q0.push_back(8'h9E); q0.push_back(8'(8'hC0 + k)); q0.push_back(8'(k));
            add_pkt(0, 8'hA2, 8'(8'hC0 + k), 8'(k));
        end
        send(q0, q1);
        repeat (60) @(negedge clk);
        bp_mode = 0;
        tx_ready = '1;
        check(stall_bad == 0, "R11 byte held while not ready", stall_bad, 0);
        cmp_lane(0, "R11 stalled stream intact");
    endtask

    task automatic t_overflow();
        logic [7:0] q0[$], q1[$];
        do_reset();
        for (int k = 0; k < 90; k++) begin
            q0.push_back(8'h90 + 8'(k % 16)); q0.push_back(8'(k)); q0.push_back(~8'(k));
        end
        send(q0, q1);
        for (int k = 0; k < 86; k++) add_pkt(0, 8'h94 + 8'(k % 16), 8'(k), ~8'(k));
        relay_on();
        repeat (420) @(negedge clk);
        cmp_lane(0, "R7 ring keeps 256 bytes plus held packet");
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_local_all();
        t_mask();
        t_relay_order();
        t_parallel();
        t_hunt();
        t_timeout();
        t_err();
        t_backpressure();
        t_overflow();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule